// File: doc/BRIEF.md
# Touch Digitizer SPI Slave

This block is an SPI slave that stands in for a resistive touch-panel digitizer. A host selects it, sends a command byte with its top bit set naming one of eight channels, and then clocks out two reply bytes that together carry a 12-bit reading. Every byte after those two reads back as zero until another command byte arrives. The block samples a pen-contact flag and the pointer's pixel coordinates, scales them to 12-bit panel readings with fixed linear formulas, and keeps a registered active-low pen status output.

The SPI pins are oversampled in the system clock domain. The bus runs in mode 0: the idle clock is low, MOSI is captured on the rising edge, and MISO is sent MSB first and changes after the falling edge. The reading is captured when the command byte completes. Touch inputs that move while the reply is being read do not affect it.

Top module: `touch_adc_spi`

## Requirements
- R1: After reset, `spi_miso` is 0 and `pen_irq_n` is 1.
- R2: A received byte with bit 7 = 1 is a command byte. Its channel code is in bits 6:4. The byte clocked out right after it is `{1'b0, result[11:5]}`.
- R3: The second byte after a command byte is `{result[4:0], 3'b000}`.
- R4: Every later byte is 0x00 until the next command byte.
- R5: Channel code 5 returns `pen_x * 3536 / 256 + 256` when `pen_touch` = 1, and 0 when it is 0.
- R6: Channel code 1 returns `pen_y * 3696 / 192 + 176` when `pen_touch` = 1, saturated at 0xFFF. It returns 0xFFF when `pen_touch` = 0.
- R7: Channel code 0 returns 0 and sets `pen_irq_n` to the inverse of `pen_touch`. A command for any other channel leaves `pen_irq_n` unchanged.
- R8: Channel codes 2, 3, 4, 6 and 7 return 0.
- R9: The reading is captured when the command byte completes. A change of `pen_touch`, `pen_x` or `pen_y` during the reply bytes does not alter them.
- R10: While `spi_cs_n` is high, `spi_miso` is 0. Deselecting drops the pending command, so a new selection returns 0x00 for data bytes until a command byte is sent.
- R11: A command byte that arrives in the middle of a reply restarts the sequence with the new channel. The byte clocked out during that command byte is the reply that was already due.
- R12: MISO is sent MSB first and holds its value across each rising SCK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Host-to-slave serial data |
| spi_miso | output | 1 | Slave-to-host serial data, registered |
| pen_touch | input | 1 | Pen contact flag |
| pen_x | input | 8 | Pointer column in pixels |
| pen_y | input | 8 | Pointer row in pixels |
| pen_irq_n | output | 1 | Pen status, low while touched at the last channel-0 command |

## Verification
The assertions check on every cycle how the reply sequence advances when a byte completes. A command byte gives a reply with a cleared top bit, the second reply has zero low bits, and the replies after that are zero. They also check that deselection clears the sequence and MISO, that the captured reading changes only at a command byte, and that the pen status changes only at a channel-0 command. The scaled values themselves, the saturation of the Y formula, MSB-first ordering, and immunity to coordinate changes mid-reply are visible only in the bench's transactions, which compare whole reply bytes against values computed from the formulas.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  // Reply sequencing state
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,  // no command pending, replies are zero
    SEQ_HI   = 2'd1,  // upper reply byte loaded
    SEQ_LO   = 2'd2   // lower reply byte loaded, zeros follow
  } seq_e;

  // Command byte layout
  localparam int CMD_BIT = 7;
  localparam int CH_LSB  = 4;
  localparam int CH_W    = 3;

  // Channel codes with live behaviour; all others read as zero
  localparam logic [CH_W-1:0] CH_TEMP0 = 3'd0;
  localparam logic [CH_W-1:0] CH_Y     = 3'd1;
  localparam logic [CH_W-1:0] CH_X     = 3'd5;
endpackage

// File: rtl/tsc_sync.sv
module tsc_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RST_VAL;
        else     chain[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RST_VAL;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tsc_spi_front.sv
module tsc_spi_front #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              cs_sel,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              spi_miso
);
  localparam int               CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(BYTE_W - 1);

  logic [2:0]        pins_s;
  logic              sck_s, mosi_s, sck_prev;
  logic              sck_rise, sck_fall;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_shift, tx_shift;

  // Pin order {mosi, cs_n, sck}; chip select resets inactive
  tsc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_mosi, spi_cs_n, spi_sck}),
    .q   (pins_s)
  );

  assign sck_s    = pins_s[0];
  assign cs_sel   = ~pins_s[1];
  assign mosi_s   = pins_s[2];
  assign sck_rise = cs_sel &  sck_s & ~sck_prev;
  assign sck_fall = cs_sel & ~sck_s &  sck_prev;

  always_ff @(posedge clk) begin
    if (rst) sck_prev <= 1'b0;
    else     sck_prev <= sck_s;
  end

  // Receive path: capture on rising edge, flag every full byte
  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt   <= '0;
      rx_shift  <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
    end else if (!cs_sel) begin
      bit_cnt   <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (sck_rise) begin
        rx_shift <= {rx_shift[BYTE_W-2:0], mosi_s};
        if (bit_cnt == LAST) begin
          bit_cnt   <= '0;
          rx_byte   <= {rx_shift[BYTE_W-2:0], mosi_s};
          byte_done <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  // Transmit path: load at the falling edge that closes a byte, else shift
  always_ff @(posedge clk) begin
    if (rst || !cs_sel) begin
      tx_shift <= '0;
    end else if (sck_fall) begin
      if (bit_cnt == '0) tx_shift <= tx_byte;
      else               tx_shift <= {tx_shift[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) spi_miso <= 1'b0;
    else     spi_miso <= cs_sel & tx_shift[BYTE_W-1];
  end
endmodule

// File: rtl/tsc_scaler.sv
module tsc_scaler
  import tsc_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int RES_W    = 12,
  parameter int X_SPAN   = 3536,
  parameter int X_PIXELS = 256,
  parameter int X_OFFSET = 256,
  parameter int Y_SPAN   = 3696,
  parameter int Y_PIXELS = 192,
  parameter int Y_OFFSET = 176
) (
  input  logic [CH_W-1:0]  chan,
  input  logic             touch,
  input  logic [PIX_W-1:0] px,
  input  logic [PIX_W-1:0] py,
  output logic [RES_W-1:0] result
);
  localparam int                PROD_W  = PIX_W + RES_W + 2;
  localparam logic [PROD_W-1:0] RES_MAX = PROD_W'((1 << RES_W) - 1);

  logic [PROD_W-1:0] x_full, y_full;
  logic [RES_W-1:0]  x_res, y_res;

  function automatic logic [RES_W-1:0] clamp(input logic [PROD_W-1:0] v);
    if (v > RES_MAX) return RES_MAX[RES_W-1:0];
    return v[RES_W-1:0];
  endfunction

  always_comb begin
    x_full = (PROD_W'(px) * PROD_W'(X_SPAN)) / PROD_W'(X_PIXELS) + PROD_W'(X_OFFSET);
    y_full = (PROD_W'(py) * PROD_W'(Y_SPAN)) / PROD_W'(Y_PIXELS) + PROD_W'(Y_OFFSET);
    x_res  = clamp(x_full);
    y_res  = clamp(y_full);
    case (chan)
      CH_X:    result = touch ? x_res : '0;
      CH_Y:    result = touch ? y_res : RES_MAX[RES_W-1:0];
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/tsc_reply_seq.sv
module tsc_reply_seq
  import tsc_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int RES_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_sel,
  input  logic              byte_done,
  input  logic              is_cmd,
  input  logic [CH_W-1:0]   cmd_chan,
  input  logic              touch,
  input  logic [RES_W-1:0]  conv,
  output logic [BYTE_W-1:0] tx_byte,
  output seq_e              stage,
  output logic [RES_W-1:0]  result_q,
  output logic              pen_irq_n
);
  localparam int HI_BITS = BYTE_W - 1;
  localparam int LO_BITS = RES_W - HI_BITS;
  localparam int LO_PAD  = BYTE_W - LO_BITS;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage     <= SEQ_IDLE;
      tx_byte   <= '0;
      result_q  <= '0;
      pen_irq_n <= 1'b1;
    end else if (!cs_sel) begin
      stage   <= SEQ_IDLE;
      tx_byte <= '0;
    end else if (byte_done) begin
      if (is_cmd) begin
        result_q <= conv;
        tx_byte  <= {1'b0, conv[RES_W-1:LO_BITS]};
        stage    <= SEQ_HI;
        if (cmd_chan == CH_TEMP0) pen_irq_n <= ~touch;
      end else if (stage == SEQ_HI) begin
        tx_byte <= {result_q[LO_BITS-1:0], {LO_PAD{1'b0}}};
        stage   <= SEQ_LO;
      end else begin
        tx_byte <= '0;
      end
    end
  end
endmodule

// File: rtl/touch_adc_spi.sv
module touch_adc_spi
  import tsc_pkg::*;
#(
  parameter int PIX_W       = 8,
  parameter int RES_W       = 12,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spi_sck,
  input  logic             spi_cs_n,
  input  logic             spi_mosi,
  output logic             spi_miso,
  input  logic             pen_touch,
  input  logic [PIX_W-1:0] pen_x,
  input  logic [PIX_W-1:0] pen_y,
  output logic             pen_irq_n
);
  logic              cs_sel, byte_done;
  logic [BYTE_W-1:0] rx_byte, tx_byte;
  logic [RES_W-1:0]  conv, result_q;
  seq_e              seq_stage;
  logic              touch_q;
  logic [PIX_W-1:0]  px_q, py_q;

  // Input register stage for the touch sources
  always_ff @(posedge clk) begin
    if (rst) begin
      touch_q <= 1'b0;
      px_q    <= '0;
      py_q    <= '0;
    end else begin
      touch_q <= pen_touch;
      px_q    <= pen_x;
      py_q    <= pen_y;
    end
  end

  tsc_spi_front #(.BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk       (clk),
    .rst       (rst),
    .spi_sck   (spi_sck),
    .spi_cs_n  (spi_cs_n),
    .spi_mosi  (spi_mosi),
    .tx_byte   (tx_byte),
    .cs_sel    (cs_sel),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .spi_miso  (spi_miso)
  );

  tsc_scaler #(.PIX_W(PIX_W), .RES_W(RES_W)) u_scale (
    .chan   (rx_byte[CH_LSB +: CH_W]),
    .touch  (touch_q),
    .px     (px_q),
    .py     (py_q),
    .result (conv)
  );

  tsc_reply_seq #(.BYTE_W(BYTE_W), .RES_W(RES_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .cs_sel    (cs_sel),
    .byte_done (byte_done),
    .is_cmd    (rx_byte[CMD_BIT]),
    .cmd_chan  (rx_byte[CH_LSB +: CH_W]),
    .touch     (touch_q),
    .conv      (conv),
    .tx_byte   (tx_byte),
    .stage     (seq_stage),
    .result_q  (result_q),
    .pen_irq_n (pen_irq_n)
  );
endmodule

// File: rtl/touch_adc_spi_chk.sv
module touch_adc_spi_chk
  import tsc_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int RES_W  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_sel,
  input logic              byte_done,
  input logic [BYTE_W-1:0] rx_byte,
  input logic [BYTE_W-1:0] tx_byte,
  input seq_e              stage,
  input logic [RES_W-1:0]  result_q,
  input logic              pen_irq_n,
  input logic              spi_miso
);
  logic got_cmd, got_data, got_temp0;
  assign got_cmd   = cs_sel && byte_done && rx_byte[BYTE_W-1];
  assign got_data  = cs_sel && byte_done && !rx_byte[BYTE_W-1];
  assign got_temp0 = got_cmd && (rx_byte[BYTE_W-2:0] < 7'h10);

  // R2
  cmd_hi_chk: assert property (@(posedge clk) disable iff (rst)
    got_cmd |=> (tx_byte[BYTE_W-1] == 1'b0) && (stage == SEQ_HI));

  // R3
  lo_reply_chk: assert property (@(posedge clk) disable iff (rst)
    (got_data && stage == SEQ_HI) |=> (tx_byte[2:0] == 3'b000) && (stage == SEQ_LO));

  // R4
  zero_tail_chk: assert property (@(posedge clk) disable iff (rst)
    (got_data && stage != SEQ_HI) |=> (tx_byte == '0));

  // R10
  desel_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_sel |=> (stage == SEQ_IDLE) && (tx_byte == '0));

  // R10
  desel_miso_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_sel |=> !spi_miso);

  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    !got_cmd |=> $stable(result_q));

  // R7
  pen_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !got_temp0 |=> $stable(pen_irq_n));
endmodule

bind touch_adc_spi touch_adc_spi_chk #(.BYTE_W(BYTE_W), .RES_W(RES_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_sel    (cs_sel),
  .byte_done (byte_done),
  .rx_byte   (rx_byte),
  .tx_byte   (tx_byte),
  .stage     (seq_stage),
  .result_q  (result_q),
  .pen_irq_n (pen_irq_n),
  .spi_miso  (spi_miso)
);

// File: tb/touch_adc_spi_bench.sv
`timescale 1ns/1ps
module touch_adc_spi_bench;
  localparam int HALF  = 8;
  localparam int LIMIT = 150000;
  localparam int NV    = 15;

  // {chan[2:0], touch, x[7:0], y[7:0], expected[11:0]}
  localparam logic [31:0] VEC [NV] = '{
    {3'd5, 1'b1, 8'h00, 8'h00, 12'h100},
    {3'd5, 1'b1, 8'hFF, 8'h00, 12'hEC2},
    {3'd5, 1'b1, 8'h80, 8'h33, 12'h7E8},
    {3'd5, 1'b0, 8'h80, 8'h33, 12'h000},
    {3'd1, 1'b1, 8'h10, 8'h00, 12'h0B0},
    {3'd1, 1'b1, 8'h00, 8'hBF, 12'hF0C},
    {3'd1, 1'b1, 8'h00, 8'h60, 12'h7E8},
    {3'd1, 1'b0, 8'h00, 8'h60, 12'hFFF},
    {3'd1, 1'b1, 8'h00, 8'hFF, 12'hFFF},
    {3'd2, 1'b1, 8'h40, 8'h40, 12'h000},
    {3'd3, 1'b1, 8'h40, 8'h40, 12'h000},
    {3'd4, 1'b1, 8'h40, 8'h40, 12'h000},
    {3'd6, 1'b1, 8'h40, 8'h40, 12'h000},
    {3'd7, 1'b1, 8'h40, 8'h40, 12'h000},
    {3'd0, 1'b1, 8'h40, 8'h40, 12'h000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, touch = 1'b0;
  logic [7:0] px = '0, py = '0;
  logic miso, pen_n;
  int checks = 0, fails = 0, cyc = 0, hold_err = 0;

  always #4 clk = ~clk;

  touch_adc_spi u_touch_adc_spi (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .pen_touch(touch), .pen_x(px), .pen_y(py), .pen_irq_n(pen_n)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] hi_of(input logic [11:0] r);
    return {1'b0, r[11:5]};
  endfunction

  function automatic logic [7:0] lo_of(input logic [11:0] r);
    return {r[4:0], 3'b000};
  endfunction

  function automatic logic [7:0] cmd(input logic [2:0] ch);
    return {1'b1, ch, 4'b0000};
  endfunction

  task automatic xfer(input logic [7:0] d, output logic [7:0] q);
    for (int i = 7; i >= 0; i--) begin
      mosi = d[i];
      wait_clk(HALF);
      q[i] = miso;
      sck = 1'b1;
      wait_clk(HALF - 2);
      if (miso !== q[i]) hold_err++;
      wait_clk(2);
      sck = 1'b0;
    end
    wait_clk(HALF);
  endtask

  task automatic sel();
    cs_n = 1'b0;
    wait_clk(4);
  endtask

  task automatic desel();
    cs_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic set_pen(input logic t, input logic [7:0] x, input logic [7:0] y);
    touch = t; px = x; py = y;
    wait_clk(3);
  endtask

  task automatic run_conv(input logic [2:0] ch, output logic [7:0] hi,
                          output logic [7:0] lo, output logic [7:0] tail);
    logic [7:0] dummy;
    sel();
    xfer(cmd(ch), dummy);
    xfer(8'h00, hi);
    xfer(8'h00, lo);
    xfer(8'h00, tail);
    desel();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT) begin
      fails++;
      $display("FAIL watchdog actual=%0d cycles expected below %0d", cyc, LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] hi, lo, tail, q;
    logic [11:0] e;
    string req;

    wait_clk(5);
    rst = 1'b0;
    wait_clk(1);
    // R1 reset state
    check("R1 miso", {11'd0, miso}, 12'd0);
    check("R1 pen_irq_n", {11'd0, pen_n}, 12'd1);

    // Vector table: R2 R3 R4 with R5 R6 R7 R8 values
    for (int i = 0; i < NV; i++) begin
      set_pen(VEC[i][20], VEC[i][19:12], VEC[i][11:4] ^ 8'h00);
      px = VEC[i][19:12];
      py = VEC[i][11:4];
      e  = VEC[i][11:0];
      set_pen(VEC[i][28], VEC[i][27:20], VEC[i][19:12]);
      case (VEC[i][31:29])
        3'd5:    req = "R2/R5";
        3'd1:    req = "R2/R6";
        3'd0:    req = "R2/R7";
        default: req = "R2/R8";
      endcase
      run_conv(VEC[i][31:29], hi, lo, tail);
      check(req, {4'd0, hi}, {4'd0, hi_of(e)});
      check("R3 second reply", {4'd0, lo}, {4'd0, lo_of(e)});
      check("R4 tail zero", {4'd0, tail}, 12'd0);
    end

    // R7 pen status follows channel 0 only
    set_pen(1'b1, 8'h20, 8'h20);
    run_conv(3'd0, hi, lo, tail);
    check("R7 pen low when touched", {11'd0, pen_n}, 12'd0);
    set_pen(1'b0, 8'h20, 8'h20);
    run_conv(3'd5, hi, lo, tail);
    check("R7 pen unchanged by X command", {11'd0, pen_n}, 12'd0);
    run_conv(3'd0, hi, lo, tail);
    check("R7 pen high when released", {11'd0, pen_n}, 12'd1);

    // R9 capture at command end: x moves during reply
    set_pen(1'b1, 8'd10, 8'd0);
    sel();
    xfer(cmd(3'd5), q);
    px = 8'd200;
    xfer(8'h00, hi);
    xfer(8'h00, lo);
    desel();
    e = 12'(10 * 3536 / 256 + 256);
    check("R9 hi unaffected", {4'd0, hi}, {4'd0, hi_of(e)});
    check("R9 lo unaffected", {4'd0, lo}, {4'd0, lo_of(e)});

    // R11 command mid-reply restarts
    set_pen(1'b1, 8'h80, 8'h00);
    sel();
    xfer(cmd(3'd5), q);
    xfer(8'h00, hi);
    xfer(cmd(3'd1), lo);
    check("R11 first hi", {4'd0, hi}, {4'd0, hi_of(12'h7E8)});
    check("R11 reply during new command", {4'd0, lo}, {4'd0, lo_of(12'h7E8)});
    xfer(8'h00, hi);
    xfer(8'h00, lo);
    desel();
    check("R11 restarted hi", {4'd0, hi}, {4'd0, hi_of(12'h0B0)});
    check("R11 restarted lo", {4'd0, lo}, {4'd0, lo_of(12'h0B0)});

    // R10 deselect drops the pending command
    sel();
    xfer(cmd(3'd1), q);
    xfer(8'h00, hi);
    desel();
    check("R10 miso idle while deselected", {11'd0, miso}, 12'd0);
    sel();
    xfer(8'h00, hi);
    xfer(8'h00, lo);
    desel();
    check("R10 first byte after reselect", {4'd0, hi}, 12'd0);
    check("R10 second byte after reselect", {4'd0, lo}, 12'd0);

    // R12 MISO held across every rising edge
    check("R12 miso stable at rising edges", 12'(hold_err), 12'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule